// File: doc/BRIEF.md
# VLAN Resolution Table

This block holds the VLAN resolution table of a small multi-port Ethernet switch. Each of its 32 entries stores a 12-bit VLAN identifier, a port membership mask and an egress tag mask, one bit per switch port. Software reaches the table through a simple memory-mapped register port with one 32-bit word per entry. Control bits in a written word select which of the two masks takes the low bits of the word. A separate control bit flips, per entry, which mask a read returns, so software can read either mask through the same word.

The forwarding path uses the lookup port. It presents a VLAN ID and the ingress port number. One cycle later the table returns whether a live entry carries that ID, the index of that entry, whether the ingress port belongs to the VLAN, and the entry's egress tag mask. An entry with an empty membership mask is free: it never matches, and software may give it a new ID. A lookup made in the same cycle as a register write sees the table as it was before that write.

Top module: `vlan_res_table`

## Requirements
- R1: After reset every entry holds VLAN ID 0, an empty membership mask, an empty tag mask and the membership read view. Reads of any entry return zero and no lookup hits.
- R2: Entry i sits at word address i (0 to 31). A read returns the VLAN ID in bits 16:5, the mask chosen by the read view in bits 4:0, and the view in bit 28 (1 = tag mask). All other bits read as zero.
- R3: A write to an entry with bit 28 clear always stores bits 16:5 as the entry's VLAN ID.
- R4: A write with bit 28 clear and bit 30 set stores bits 4:0 as the membership mask.
- R5: A write with bit 28 clear and bit 29 set stores bits 4:0 as the tag mask. With both 30 and 29 set, both masks take the same value. With neither set, both masks keep their values.
- R6: A write with bit 28 set flips the read view of that entry only and changes no stored field, whatever its other bits hold. A second such write restores the membership view.
- R7: A read request gives reg_rvalid_o high with the data in the cycle after the request, for exactly one cycle. A write never raises reg_rvalid_o.
- R8: Addresses 32 and above are unmapped. Reads there return zero, and writes there change no entry.
- R9: The lookup result appears, with lk_rvalid_o high, in the cycle after lk_valid_i. On a hit it gives the entry index and that entry's tag mask. lk_member_o gives the membership bit of lk_port_i, and is 0 for a port number of 5 or more.
- R10: Entries with an empty membership mask never match. When several live entries carry the looked-up ID, the lowest index wins.
- R11: On a miss, or in a cycle without a request, lk_hit_o, lk_index_o, lk_member_o and lk_tagmask_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_valid_i | input | 1 | Register access request |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 8 | Word address |
| reg_wdata_i | input | 32 | Write data and control bits |
| reg_rvalid_o | output | 1 | Read data valid |
| reg_rdata_o | output | 32 | Read data |
| lk_valid_i | input | 1 | Lookup request |
| lk_vid_i | input | 12 | VLAN ID to look up |
| lk_port_i | input | 3 | Ingress port number |
| lk_rvalid_o | output | 1 | Lookup result valid |
| lk_hit_o | output | 1 | A live entry matched |
| lk_index_o | output | 5 | Index of the winning entry |
| lk_member_o | output | 1 | Ingress port is a member |
| lk_tagmask_o | output | 5 | Egress tag mask of the winning entry |

## Verification
The assertions assume that reg_valid_i and lk_valid_i are single-cycle requests held low outside a request, and that write data bit 28 is the only control that suppresses field updates. The bench drives every request for exactly one cycle, at the falling edge. It keeps register and lookup traffic in separate cycles, so that each result can be compared against a model that is updated only when a write has landed. Unmapped addresses, out-of-range port numbers and free entries that share a live ID are sent on purpose, because those are the inputs the properties single out.

// File: rtl/vrt_pkg.sv
// Package: vrt_pkg
// Fixed bit positions of the per-entry register word of the VLAN resolution
// table. Assumes a 32-bit register data path.
package vrt_pkg;
    localparam int REG_W      = 32;
    localparam int BIT_WR_MEM = 30;  // write selects membership mask
    localparam int BIT_WR_TAG = 29;  // write selects tag mask
    localparam int BIT_VIEW   = 28;  // toggle read view / read-back of view
endpackage

// File: rtl/vrt_entry_store.sv
// Module: vrt_entry_store
// Holds the VID, membership mask, tag mask and read-view flag of every entry.
// Assumes at most one decoded write per cycle (wr_en with wr_idx in range).
module vrt_entry_store #(
    parameter int N_ENTRIES = 32,
    parameter int N_PORTS   = 5,
    parameter int VID_W     = 12,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [IDX_W-1:0]                    wr_idx,
    input  logic                                wr_toggle,
    input  logic                                wr_sel_mem,
    input  logic                                wr_sel_tag,
    input  logic [VID_W-1:0]                    wr_vid,
    input  logic [N_PORTS-1:0]                  wr_mask,
    output logic [N_ENTRIES-1:0][VID_W-1:0]     vid_o,
    output logic [N_ENTRIES-1:0][N_PORTS-1:0]   mem_o,
    output logic [N_ENTRIES-1:0][N_PORTS-1:0]   tag_o,
    output logic [N_ENTRIES-1:0]                view_o
);

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
        logic hit_w;
        assign hit_w = wr_en && (wr_idx == IDX_W'(i));

        // Update one entry: a toggle write only flips the view, else fields load
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vid_o[i]  <= '0;
                mem_o[i]  <= '0;
                tag_o[i]  <= '0;
                view_o[i] <= 1'b0;
            end else if (hit_w) begin
                if (wr_toggle) begin
                    view_o[i] <= ~view_o[i];
                end else begin
                    vid_o[i] <= wr_vid;
                    if (wr_sel_mem) mem_o[i] <= wr_mask;
                    if (wr_sel_tag) tag_o[i] <= wr_mask;
                end
            end
        end
    end

    // R6
    toggle_keeps_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_toggle) |=> ($stable(vid_o) && $stable(mem_o) && $stable(tag_o)));

    // R4
    mem_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_toggle && wr_sel_mem) |=> (mem_o[$past(wr_idx)] == $past(wr_mask)));

    // R5
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_toggle && !wr_sel_mem && !wr_sel_tag) |=> ($stable(mem_o) && $stable(tag_o)));

endmodule

// File: rtl/vrt_regport.sv
// Module: vrt_regport
// Decodes register accesses into entry writes and returns read data one cycle
// after a read request. Assumes requests last one cycle each.
module vrt_regport
    import vrt_pkg::*;
#(
    parameter int N_ENTRIES = 32,
    parameter int N_PORTS   = 5,
    parameter int VID_W     = 12,
    parameter int ADDR_W    = 8,
    localparam int IDX_W    = $clog2(N_ENTRIES),
    localparam int VID_LSB  = N_PORTS,
    localparam int VID_MSB  = VID_LSB + VID_W - 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                reg_valid_i,
    input  logic                                reg_write_i,
    input  logic [ADDR_W-1:0]                   reg_addr_i,
    input  logic [REG_W-1:0]                    reg_wdata_i,
    input  logic [N_ENTRIES-1:0][VID_W-1:0]     vid_i,
    input  logic [N_ENTRIES-1:0][N_PORTS-1:0]   mem_i,
    input  logic [N_ENTRIES-1:0][N_PORTS-1:0]   tag_i,
    input  logic [N_ENTRIES-1:0]                view_i,
    output logic                                wr_en,
    output logic [IDX_W-1:0]                    wr_idx,
    output logic                                wr_toggle,
    output logic                                wr_sel_mem,
    output logic                                wr_sel_tag,
    output logic [VID_W-1:0]                    wr_vid,
    output logic [N_PORTS-1:0]                  wr_mask,
    output logic                                reg_rvalid_o,
    output logic [REG_W-1:0]                    reg_rdata_o
);

    logic             mapped;
    logic [IDX_W-1:0] idx;
    logic [REG_W-1:0] rd_word;
    logic             wdata_unused;

    assign mapped       = ({1'b0, reg_addr_i} < (ADDR_W+1)'(N_ENTRIES));
    assign idx          = reg_addr_i[IDX_W-1:0];
    assign wdata_unused = ^{reg_wdata_i[REG_W-1], reg_wdata_i[BIT_VIEW-1:VID_MSB+1]};

    // Split a write into field controls for the entry store
    always_comb begin
        wr_en      = reg_valid_i && reg_write_i && mapped;
        wr_idx     = idx;
        wr_toggle  = reg_wdata_i[BIT_VIEW];
        wr_sel_mem = reg_wdata_i[BIT_WR_MEM];
        wr_sel_tag = reg_wdata_i[BIT_WR_TAG];
        wr_vid     = reg_wdata_i[VID_MSB:VID_LSB];
        wr_mask    = reg_wdata_i[N_PORTS-1:0];
    end

    // Assemble the read word of the addressed entry using its current view
    always_comb begin
        rd_word = '0;
        if (mapped) begin
            rd_word[BIT_VIEW]        = view_i[idx];
            rd_word[VID_MSB:VID_LSB] = vid_i[idx];
            rd_word[N_PORTS-1:0]     = view_i[idx] ? tag_i[idx] : mem_i[idx];
        end
    end

    // Register read data and its valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rvalid_o <= 1'b0;
            reg_rdata_o  <= '0;
        end else begin
            reg_rvalid_o <= reg_valid_i && !reg_write_i;
            reg_rdata_o  <= (reg_valid_i && !reg_write_i) ? rd_word : '0;
        end
    end

    // R7
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid_i && !reg_write_i) |=> reg_rvalid_o);

    // R7
    write_no_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_valid_i || reg_write_i) |=> !reg_rvalid_o);

    // R8
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid_i && !reg_write_i && !mapped) |=> (reg_rdata_o == '0));

    // R2
    spare_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rvalid_o |-> (reg_rdata_o[REG_W-1:BIT_VIEW+1] == '0 &&
                          reg_rdata_o[BIT_VIEW-1:VID_MSB+1] == '0));

endmodule

// File: rtl/vrt_lookup.sv
// Module: vrt_lookup
// Compares a VID against all entries in parallel, picks the lowest-indexed
// live match and registers the result. Assumes lk_valid_i is a per-cycle strobe.
module vrt_lookup #(
    parameter int N_ENTRIES = 32,
    parameter int N_PORTS   = 5,
    parameter int VID_W     = 12,
    localparam int IDX_W    = $clog2(N_ENTRIES),
    localparam int PORT_W   = $clog2(N_PORTS)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                lk_valid_i,
    input  logic [VID_W-1:0]                    lk_vid_i,
    input  logic [PORT_W-1:0]                   lk_port_i,
    input  logic [N_ENTRIES-1:0][VID_W-1:0]     vid_i,
    input  logic [N_ENTRIES-1:0][N_PORTS-1:0]   mem_i,
    input  logic [N_ENTRIES-1:0][N_PORTS-1:0]   tag_i,
    output logic                                lk_rvalid_o,
    output logic                                lk_hit_o,
    output logic [IDX_W-1:0]                    lk_index_o,
    output logic                                lk_member_o,
    output logic [N_PORTS-1:0]                  lk_tagmask_o
);

    logic [N_ENTRIES-1:0] match;
    logic                 found;
    logic [IDX_W-1:0]     win;
    logic [N_PORTS-1:0]   win_mem;
    logic                 port_ok;

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cmp
        assign match[i] = (vid_i[i] == lk_vid_i) && (|mem_i[i]);
    end

    // Priority pick: scan downward so the lowest matching index is kept
    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                found = 1'b1;
                win   = IDX_W'(i);
            end
        end
    end

    assign win_mem = mem_i[win];
    assign port_ok = (int'(lk_port_i) < N_PORTS);

    // Register the lookup result, zero when no request or no hit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_rvalid_o  <= 1'b0;
            lk_hit_o     <= 1'b0;
            lk_index_o   <= '0;
            lk_member_o  <= 1'b0;
            lk_tagmask_o <= '0;
        end else begin
            lk_rvalid_o  <= lk_valid_i;
            lk_hit_o     <= lk_valid_i && found;
            lk_index_o   <= (lk_valid_i && found) ? win : '0;
            lk_member_o  <= lk_valid_i && found && port_ok && win_mem[lk_port_i];
            lk_tagmask_o <= (lk_valid_i && found) ? tag_i[win] : '0;
        end
    end

    // R9
    lookup_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid_i |=> lk_rvalid_o);

    // R11
    idle_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid_i |=> (!lk_hit_o && !lk_member_o && lk_tagmask_o == '0));

    // R11
    member_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_member_o |-> lk_hit_o);

    // R10
    one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid_i && match != '0) |=> lk_hit_o);

endmodule

// File: rtl/vlan_res_table.sv
// Module: vlan_res_table
// VLAN resolution table: per-entry register access with two masks sharing one
// word, plus a registered parallel lookup. Assumes a single clock domain.
module vlan_res_table #(
    parameter int N_ENTRIES = 32,
    parameter int N_PORTS   = 5,
    parameter int VID_W     = 12,
    parameter int ADDR_W    = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             reg_valid_i,
    input  logic                             reg_write_i,
    input  logic [ADDR_W-1:0]                reg_addr_i,
    input  logic [31:0]                      reg_wdata_i,
    output logic                             reg_rvalid_o,
    output logic [31:0]                      reg_rdata_o,
    input  logic                             lk_valid_i,
    input  logic [VID_W-1:0]                 lk_vid_i,
    input  logic [$clog2(N_PORTS)-1:0]       lk_port_i,
    output logic                             lk_rvalid_o,
    output logic                             lk_hit_o,
    output logic [$clog2(N_ENTRIES)-1:0]     lk_index_o,
    output logic                             lk_member_o,
    output logic [N_PORTS-1:0]               lk_tagmask_o
);

    localparam int IDX_W = $clog2(N_ENTRIES);

    logic [N_ENTRIES-1:0][VID_W-1:0]   vid_a;
    logic [N_ENTRIES-1:0][N_PORTS-1:0] mem_a;
    logic [N_ENTRIES-1:0][N_PORTS-1:0] tag_a;
    logic [N_ENTRIES-1:0]              view_a;
    logic                              wr_en;
    logic [IDX_W-1:0]                  wr_idx;
    logic                              wr_toggle;
    logic                              wr_sel_mem;
    logic                              wr_sel_tag;
    logic [VID_W-1:0]                  wr_vid;
    logic [N_PORTS-1:0]                wr_mask;

    vrt_regport #(
        .N_ENTRIES(N_ENTRIES), .N_PORTS(N_PORTS), .VID_W(VID_W), .ADDR_W(ADDR_W)
    ) u_regport (
        .clk(clk), .rst_n(rst_n),
        .reg_valid_i(reg_valid_i), .reg_write_i(reg_write_i),
        .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .vid_i(vid_a), .mem_i(mem_a), .tag_i(tag_a), .view_i(view_a),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_toggle(wr_toggle),
        .wr_sel_mem(wr_sel_mem), .wr_sel_tag(wr_sel_tag),
        .wr_vid(wr_vid), .wr_mask(wr_mask),
        .reg_rvalid_o(reg_rvalid_o), .reg_rdata_o(reg_rdata_o)
    );

    vrt_entry_store #(
        .N_ENTRIES(N_ENTRIES), .N_PORTS(N_PORTS), .VID_W(VID_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_toggle(wr_toggle),
        .wr_sel_mem(wr_sel_mem), .wr_sel_tag(wr_sel_tag),
        .wr_vid(wr_vid), .wr_mask(wr_mask),
        .vid_o(vid_a), .mem_o(mem_a), .tag_o(tag_a), .view_o(view_a)
    );

    vrt_lookup #(
        .N_ENTRIES(N_ENTRIES), .N_PORTS(N_PORTS), .VID_W(VID_W)
    ) u_lookup (
        .clk(clk), .rst_n(rst_n),
        .lk_valid_i(lk_valid_i), .lk_vid_i(lk_vid_i), .lk_port_i(lk_port_i),
        .vid_i(vid_a), .mem_i(mem_a), .tag_i(tag_a),
        .lk_rvalid_o(lk_rvalid_o), .lk_hit_o(lk_hit_o), .lk_index_o(lk_index_o),
        .lk_member_o(lk_member_o), .lk_tagmask_o(lk_tagmask_o)
    );

endmodule

// File: tb/sim_vlan_res_table.sv
// Directed bench for vlan_res_table; one task per scenario, each self-checking
// against a model built from the requirements.
module sim_vlan_res_table;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid_i = 1'b0, reg_write_i = 1'b0;
    logic [7:0]  reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic        reg_rvalid_o;
    logic [31:0] reg_rdata_o;
    logic        lk_valid_i = 1'b0;
    logic [11:0] lk_vid_i = '0;
    logic [2:0]  lk_port_i = '0;
    logic        lk_rvalid_o, lk_hit_o, lk_member_o;
    logic [4:0]  lk_index_o, lk_tagmask_o;

    int n_cmp = 0;
    int n_bad = 0;

    logic [11:0] m_vid [32];
    logic [4:0]  m_mem [32];
    logic [4:0]  m_tag [32];
    logic        m_view[32];

    always #4 clk = ~clk;

    vlan_res_table u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_valid_i(reg_valid_i), .reg_write_i(reg_write_i),
        .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rvalid_o(reg_rvalid_o), .reg_rdata_o(reg_rdata_o),
        .lk_valid_i(lk_valid_i), .lk_vid_i(lk_vid_i), .lk_port_i(lk_port_i),
        .lk_rvalid_o(lk_rvalid_o), .lk_hit_o(lk_hit_o), .lk_index_o(lk_index_o),
        .lk_member_o(lk_member_o), .lk_tagmask_o(lk_tagmask_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic model_write(int a, logic [31:0] d);
        if (a < 32) begin
            if (d[28]) m_view[a] = ~m_view[a];
            else begin
                m_vid[a] = d[16:5];
                if (d[30]) m_mem[a] = d[4:0];
                if (d[29]) m_tag[a] = d[4:0];
            end
        end
    endtask

    task automatic reg_wr(int a, logic [31:0] d);
        @(negedge clk);
        reg_valid_i = 1'b1; reg_write_i = 1'b1; reg_addr_i = 8'(a); reg_wdata_i = d;
        @(negedge clk);
        reg_valid_i = 1'b0; reg_write_i = 1'b0;
        model_write(a, d);
    endtask

    task automatic reg_rd(int a, output logic [31:0] d, output logic rv);
        @(negedge clk);
        reg_valid_i = 1'b1; reg_write_i = 1'b0; reg_addr_i = 8'(a);
        @(negedge clk);
        reg_valid_i = 1'b0;
        d = reg_rdata_o; rv = reg_rvalid_o;
    endtask

    function automatic logic [31:0] exp_word(int a);
        logic [31:0] w = '0;
        if (a < 32) begin
            w[28]   = m_view[a];
            w[16:5] = m_vid[a];
            w[4:0]  = m_view[a] ? m_tag[a] : m_mem[a];
        end
        return w;
    endfunction

    task automatic check_rd(string req, int a);
        logic [31:0] d;
        logic rv;
        reg_rd(a, d, rv);
        check({req, " rvalid"}, 32'(rv), 32'd1);
        check(req, d, exp_word(a));
    endtask

    task automatic check_lk(string req, logic [11:0] vid, logic [2:0] port);
        logic        e_hit = 1'b0;
        logic [4:0]  e_idx = '0, e_tag = '0;
        logic        e_mem = 1'b0;
        for (int i = 31; i >= 0; i--) begin
            if (m_vid[i] == vid && m_mem[i] != 0) begin
                e_hit = 1'b1; e_idx = 5'(i);
            end
        end
        if (e_hit) begin
            e_tag = m_tag[e_idx];
            e_mem = (port < 5) ? m_mem[e_idx][port] : 1'b0;
        end
        @(negedge clk);
        lk_valid_i = 1'b1; lk_vid_i = vid; lk_port_i = port;
        @(negedge clk);
        lk_valid_i = 1'b0;
        check({req, " rvalid"}, 32'(lk_rvalid_o), 32'd1);
        check(req, {19'b0, lk_hit_o, lk_index_o, lk_member_o, lk_tagmask_o},
                   {19'b0, e_hit, e_idx, e_mem, e_tag});
    endtask

    function automatic logic [31:0] wd(logic mem, logic tag, logic tog,
                                       logic [11:0] vid, logic [4:0] mask);
        return {1'b0, mem, tag, tog, 11'b0, vid, mask};
    endfunction

    // R1: reset state
    task automatic t_reset();
        check_rd("R1 entry0", 0);
        check_rd("R1 entry31", 31);
        check_lk("R1 vid0 miss", 12'h000, 3'd0);
    endtask

    // R2 R3 R4 R5: field writes and layout
    task automatic t_fields();
        reg_wr(3, wd(1, 0, 0, 12'h123, 5'h15));
        check_rd("R4 R2 member write", 3);
        reg_wr(3, wd(0, 1, 0, 12'h123, 5'h0A));
        check_rd("R5 tag write keeps member", 3);
        reg_wr(5, wd(1, 1, 0, 12'h7FF, 5'h07));
        check_rd("R5 both masks", 5);
        reg_wr(5, wd(0, 0, 0, 12'h456, 5'h1F));
        check_rd("R3 vid only", 5);
    endtask

    // R6: read view toggle per entry
    task automatic t_toggle();
        reg_wr(3, 32'h1000_0000);
        check_rd("R6 tag view", 3);
        check_rd("R6 other entry unaffected", 5);
        reg_wr(3, wd(1, 1, 1, 12'hFFF, 5'h1F));
        check_rd("R6 toggle with junk back to member", 3);
        reg_wr(5, 32'h1000_0000);
        check_rd("R6 entry5 tag view", 5);
        reg_wr(5, 32'h1000_0000);
        check_rd("R6 entry5 restored", 5);
    endtask

    // R7: latency and rvalid pulse
    task automatic t_latency();
        logic [31:0] d;
        logic rv;
        reg_rd(3, d, rv);
        check("R7 rvalid one cycle later", 32'(rv), 32'd1);
        @(negedge clk);
        check("R7 rvalid drops", 32'(reg_rvalid_o), 32'd0);
        @(negedge clk);
        reg_valid_i = 1'b1; reg_write_i = 1'b1; reg_addr_i = 8'd9; reg_wdata_i = '0;
        @(negedge clk);
        reg_valid_i = 1'b0; reg_write_i = 1'b0;
        model_write(9, '0);
        check("R7 no rvalid on write", 32'(reg_rvalid_o), 32'd0);
    endtask

    // R8: unmapped addresses
    task automatic t_unmapped();
        reg_wr(32, wd(1, 1, 0, 12'h321, 5'h1F));
        reg_wr(35, wd(1, 1, 0, 12'h321, 5'h1F));
        check_rd("R8 read 32 zero", 32);
        check_rd("R8 read 200 zero", 200);
        check_rd("R8 entry0 untouched", 0);
        check_rd("R8 entry3 untouched", 3);
    endtask

    // R9 R10 R11: lookups
    task automatic t_lookup();
        check_lk("R9 hit port0 member", 12'h123, 3'd0);
        check_lk("R9 port1 not member", 12'h123, 3'd1);
        check_lk("R9 port7 out of range", 12'h123, 3'd7);
        reg_wr(7,  wd(0, 1, 0, 12'h055, 5'h03));
        reg_wr(10, wd(1, 1, 0, 12'h055, 5'h12));
        reg_wr(20, wd(1, 1, 0, 12'h055, 5'h0C));
        check_lk("R10 free entry skipped lowest wins", 12'h055, 3'd4);
        reg_wr(10, wd(1, 0, 0, 12'h055, 5'h00));
        check_lk("R10 freed entry gives way", 12'h055, 3'd2);
        check_lk("R11 miss all zero", 12'hABC, 3'd0);
        @(negedge clk);
        check("R11 idle outputs zero",
              {25'b0, lk_rvalid_o, lk_hit_o, lk_member_o, lk_tagmask_o[3:0]}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            m_vid[i] = '0; m_mem[i] = '0; m_tag[i] = '0; m_view[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fields();
        t_toggle();
        t_latency();
        t_unmapped();
        t_lookup();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #800000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule